// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

This block runs once after every reset and gathers the configuration words that set up the boot of a core and up to seven dependent devices. It works as a read master on a simple byte bus. Each access has an address, a read request and an 8-bit data return qualified by a valid strobe. The block fetches 32 bytes from boot memory, one per access. Every access address is a multiple of 8, so the byte always comes from the lowest lane, whatever the width of the boot port.

Every four consecutive bytes form one 32-bit word, with the first byte in the most significant position. The first word belongs to the local core. The remaining seven are offered to the dependent devices. While the fetch runs, a hold output keeps the core in its configuration state. When the last byte lands, the block raises a done flag and releases the hold. It also presents the words and the reset vector. The vector is the base address plus 0x100. The base is 0x00000000 or 0xFFF00000, chosen by a single prefix bit of the local word whose position is a parameter.

Top module: `cfg_word_fetcher`

## Requirements
- R1: Reads are issued one at a time. `rd_req` stays high and `rd_addr` stays unchanged until a rising clock edge sees `rd_valid` high. A `rd_valid` pulse while `rd_req` is low is ignored and changes no output.
- R2: The accepted addresses are 0, 8, 16, …, 248 in this order, exactly 32 of them. After the 32nd byte is accepted, `rd_req` stays low.
- R3: Byte read number 4w+k (k = 0..3) is placed in bits [31-8k : 24-8k] of word w, so the first byte of a group is the most significant.
- R4: Word 0 appears on `master_word`. Word s (s = 1..7) appears on `slave_words[32s-1 : 32s-32]`.
- R5: Once done, `vec_base` is 0x00000000 when bit PREFIX_BIT (default 22) of `master_word` is 0, and 0xFFF00000 when it is 1. `reset_vector` equals `vec_base` + 0x100.
- R6: Until done, `master_word`, `slave_words`, `vec_base` and `reset_vector` read zero and `cfg_hold` is high.
- R7: `done` rises on the clock edge that accepts the 32nd byte. It stays high and `cfg_hold` stays low until the next reset.
- R8: A low `rst_n` immediately forces `done` low, `cfg_hold` high, `rd_req` low and all word outputs to zero. After release, a new fetch starts from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | output | 32 | Boot memory byte address of the pending read |
| rd_req | output | 1 | A read is pending |
| rd_data | input | 8 | Byte returned from the lowest lane |
| rd_valid | input | 1 | `rd_data` is valid for the pending read |
| cfg_hold | output | 1 | Keeps the core in its configuration state |
| done | output | 1 | All words fetched |
| master_word | output | 32 | Configuration word of the local core |
| slave_words | output | 224 | Seven words for dependent devices, slave 1 lowest |
| vec_base | output | 32 | Reset vector base chosen by the prefix bit |
| reset_vector | output | 32 | Address of the first instruction after configuration |

## Verification
The assertions check on every cycle the protocol rules. These are: address stability while a read waits, the stride of 8 after each accepted byte, zero outputs and a high hold before done, the sticky done flag, the absence of requests after done, and the agreement between the prefix bit and the vector. Only the bench scenarios can show that the bytes end up in the right word and byte slot. The same holds for the exact count of 32 reads, the ignoring of stray valid pulses, and the restart from address 0 after a reset in mid-fetch. These scenarios use several memory contents, response latencies and both prefix values.

// File: rtl/cfg_fetch_pkg.sv
package cfg_fetch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } fetch_state_t;

  localparam logic [31:0] VEC_OFFSET = 32'h0000_0100;
  localparam logic [31:0] HIGH_BASE  = 32'hFFF0_0000;
  localparam logic [31:0] LOW_BASE   = 32'h0000_0000;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_fetch_seq.sv
module cfg_fetch_seq
  import cfg_fetch_pkg::*;
#(
  parameter int NUM_READS  = 32,
  parameter int CNT_W      = 5,
  parameter int ADDR_W     = 32,
  parameter int STRIDE_LG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              accept,
  output logic [CNT_W-1:0]  byte_idx,
  output logic              done
);
  localparam int PAD_W = ADDR_W - CNT_W - STRIDE_LG2;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_READS - 1);

  fetch_state_t     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  state_d = ST_FETCH;
      ST_FETCH: begin
        if (rd_valid) begin
          if (cnt_q == LAST_IDX) begin
            state_d = ST_DONE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DONE:  state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rd_req   = (state_q == ST_FETCH);
  assign accept   = rd_req && rd_valid;
  assign byte_idx = cnt_q;
  assign done     = (state_q == ST_DONE);
  assign rd_addr  = {{PAD_W{1'b0}}, cnt_q, {STRIDE_LG2{1'b0}}};
endmodule

// File: rtl/cfg_word_store.sv
module cfg_word_store #(
  parameter int NUM_WORDS      = 8,
  parameter int BYTES_PER_WORD = 4,
  parameter int CNT_W          = 5
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [CNT_W-1:0]                       byte_idx,
  input  logic [7:0]                             byte_in,
  output logic [NUM_WORDS*BYTES_PER_WORD*8-1:0]  words
);
  localparam int WORD_W = BYTES_PER_WORD * 8;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
      localparam int SLOT = w * BYTES_PER_WORD + b;
      logic [7:0] slot_q, slot_d;
      logic       slot_en;

      assign slot_en = wr_en && (byte_idx == CNT_W'(SLOT));

      always_comb begin
        slot_d = slot_q;
        if (slot_en) slot_d = byte_in;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
      end

      // first byte of a group lands in the most significant slot
      assign words[w*WORD_W + WORD_W - 1 - 8*b -: 8] = slot_q;
    end
  end
endmodule

// File: rtl/cfg_vec_select.sv
module cfg_vec_select
  import cfg_fetch_pkg::*;
#(
  parameter int PREFIX_BIT = 22,
  parameter int ADDR_W     = 32
) (
  input  logic [31:0]       master_word,
  input  logic              done,
  output logic [ADDR_W-1:0] vec_base,
  output logic [ADDR_W-1:0] reset_vector
);
  logic [ADDR_W-1:0] base_sel;

  always_comb begin
    base_sel = master_word[PREFIX_BIT] ? ADDR_W'(HIGH_BASE) : ADDR_W'(LOW_BASE);
    if (done) begin
      vec_base     = base_sel;
      reset_vector = base_sel + ADDR_W'(VEC_OFFSET);
    end else begin
      vec_base     = '0;
      reset_vector = '0;
    end
  end
endmodule

// File: rtl/cfg_word_fetcher.sv
module cfg_word_fetcher #(
  parameter int NUM_WORDS      = 8,
  parameter int BYTES_PER_WORD = 4,
  parameter int ADDR_W         = 32,
  parameter int STRIDE_LG2     = 3,
  parameter int PREFIX_BIT     = 22,
  parameter int SYNC_STAGES    = 2,
  localparam int WORD_W        = BYTES_PER_WORD * 8,
  localparam int SLAVE_W       = (NUM_WORDS - 1) * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_req,
  input  logic [7:0]         rd_data,
  input  logic               rd_valid,
  output logic               cfg_hold,
  output logic               done,
  output logic [WORD_W-1:0]  master_word,
  output logic [SLAVE_W-1:0] slave_words,
  output logic [ADDR_W-1:0]  vec_base,
  output logic [ADDR_W-1:0]  reset_vector
);
  localparam int NUM_READS = NUM_WORDS * BYTES_PER_WORD;
  localparam int CNT_W     = $clog2(NUM_READS);

  logic                        rst_n_int;
  logic                        accept;
  logic [CNT_W-1:0]            byte_idx;
  logic [NUM_WORDS*WORD_W-1:0] words;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cfg_fetch_seq #(
    .NUM_READS  (NUM_READS),
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W),
    .STRIDE_LG2 (STRIDE_LG2)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rd_valid (rd_valid),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .accept   (accept),
    .byte_idx (byte_idx),
    .done     (done)
  );

  cfg_word_store #(
    .NUM_WORDS      (NUM_WORDS),
    .BYTES_PER_WORD (BYTES_PER_WORD),
    .CNT_W          (CNT_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (accept),
    .byte_idx (byte_idx),
    .byte_in  (rd_data),
    .words    (words)
  );

  assign master_word = done ? words[WORD_W-1:0] : '0;
  assign slave_words = done ? words[NUM_WORDS*WORD_W-1:WORD_W] : '0;
  assign cfg_hold    = !done;

  cfg_vec_select #(
    .PREFIX_BIT (PREFIX_BIT),
    .ADDR_W     (ADDR_W)
  ) u_vec (
    .master_word  (master_word),
    .done         (done),
    .vec_base     (vec_base),
    .reset_vector (reset_vector)
  );
endmodule

// File: rtl/cfg_fetch_checker.sv
module cfg_fetch_checker #(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_LG2 = 3,
  parameter int PREFIX_BIT = 22,
  parameter int SLAVE_W    = 224
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               rd_req,
  input logic               rd_valid,
  input logic               cfg_hold,
  input logic               done,
  input logic [31:0]        master_word,
  input logic [SLAVE_W-1:0] slave_words,
  input logic [ADDR_W-1:0]  reset_vector
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << STRIDE_LG2;

  a_r1_wait_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  a_r2_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> (done || rd_addr == $past(rd_addr) + STEP));

  a_r2_no_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  a_r5_vector_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (reset_vector == (master_word[PREFIX_BIT] ? ADDR_W'(32'hFFF0_0100)
                                                       : ADDR_W'(32'h0000_0100))));

  a_r6_zero_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (cfg_hold && master_word == '0 && slave_words == '0 && reset_vector == '0));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

bind cfg_word_fetcher cfg_fetch_checker #(
  .ADDR_W     (ADDR_W),
  .STRIDE_LG2 (STRIDE_LG2),
  .PREFIX_BIT (PREFIX_BIT),
  .SLAVE_W    (SLAVE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_addr      (rd_addr),
  .rd_req       (rd_req),
  .rd_valid     (rd_valid),
  .cfg_hold     (cfg_hold),
  .done         (done),
  .master_word  (master_word),
  .slave_words  (slave_words),
  .reset_vector (reset_vector)
);

// File: tb/cfg_word_fetcher_test.sv
`timescale 1ns/100ps
module cfg_word_fetcher_test;
  localparam int PB        = 22;
  localparam int PFX_READ  = 3 - PB / 8;
  localparam int PFX_POS   = PB % 8;

  logic         clk;
  logic         rst_n;
  logic [31:0]  rd_addr;
  logic         rd_req;
  logic [7:0]   rd_data;
  logic         rd_valid;
  logic         cfg_hold;
  logic         done;
  logic [31:0]  master_word;
  logic [223:0] slave_words;
  logic [31:0]  vec_base;
  logic [31:0]  reset_vector;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [31:0] exp_addr[$];

  cfg_word_fetcher #(.PREFIX_BIT(PB)) uut (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .cfg_hold(cfg_hold), .done(done),
    .master_word(master_word), .slave_words(slave_words),
    .vec_base(vec_base), .reset_vector(reset_vector)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a, input int seed, input bit pfx);
    logic [7:0] b;
    b = 8'(a[10:3] * 8'd37 + 8'(seed)) ^ 8'(seed >> 3);
    if (a == 32'(PFX_READ * 8)) b[PFX_POS] = pfx;
    return b;
  endfunction

  function automatic logic [31:0] exp_word(input int w, input int seed, input bit pfx);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[31-8*k -: 8] = mem_byte(32'((4*w + k) * 8), seed, pfx);
    return r;
  endfunction

  // monitor: pops expected addresses as bytes are accepted
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rd_req && rd_valid) begin
        if (exp_addr.size() == 0) begin
          chk(1'b0, "R2 extra read", 64'(rd_addr), 64'hFFFF_FFFF);
        end else begin
          logic [31:0] e;
          e = exp_addr.pop_front();
          chk(rd_addr == e, "R2 address order", 64'(rd_addr), 64'(e));
        end
      end
    end
  end

  task automatic run(input int seed, input bit pfx, input int lat, input bit stray, input int nbytes);
    logic [31:0] m_snap;
    rst_n = 1'b0; rd_valid = 1'b0; rd_data = 8'h00;
    exp_addr.delete();
    repeat (3) @(negedge clk);
    chk(!rd_req && !done && cfg_hold && master_word == 0 && slave_words == 0,
        "R8 reset state", {60'd0, rd_req, done, cfg_hold, 1'b0}, 64'h2);
    for (int i = 0; i < nbytes; i++) exp_addr.push_back(32'(i * 8));
    rst_n = 1'b1;
    for (int i = 0; i < nbytes; i++) begin
      while (!rd_req) @(negedge clk);
      repeat (lat) @(negedge clk);
      if (i == 16) begin
        chk(!done && cfg_hold && master_word == 0 && reset_vector == 0 && vec_base == 0,
            "R6 zero before done", {31'd0, done, master_word}, 64'h0);
      end
      rd_valid = 1'b1;
      rd_data  = mem_byte(rd_addr, seed, pfx);
      @(negedge clk);
      rd_valid = 1'b0;
      rd_data  = 8'h00;
    end
    if (nbytes < 32) begin
      chk(!done, "R6 partial fetch not done", 64'(done), 64'd0);
      return;
    end
    #1;
    chk(done && !cfg_hold, "R7 done after 32 bytes", {62'd0, done, cfg_hold}, 64'h2);
    chk(!rd_req && exp_addr.size() == 0, "R2 exactly 32 reads",
        64'(exp_addr.size()), 64'd0);
    chk(master_word == exp_word(0, seed, pfx), "R3 R4 master word",
        64'(master_word), 64'(exp_word(0, seed, pfx)));
    for (int s = 1; s < 8; s++)
      chk(slave_words[32*s-1 -: 32] == exp_word(s, seed, pfx), "R4 slave word",
          64'(slave_words[32*s-1 -: 32]), 64'(exp_word(s, seed, pfx)));
    chk(vec_base == (pfx ? 32'hFFF0_0000 : 32'h0), "R5 vector base",
        64'(vec_base), pfx ? 64'hFFF0_0000 : 64'h0);
    chk(reset_vector == (pfx ? 32'hFFF0_0100 : 32'h100), "R5 reset vector",
        64'(reset_vector), pfx ? 64'hFFF0_0100 : 64'h100);
    if (stray) begin
      m_snap = master_word;
      rd_valid = 1'b1;
      rd_data  = 8'hA5;
      repeat (3) @(negedge clk);
      rd_valid = 1'b0;
      #1;
      chk(master_word == m_snap && slave_words[31:0] == exp_word(1, seed, pfx),
          "R1 stray valid ignored", 64'(master_word), 64'(m_snap));
    end
    repeat (5) @(negedge clk);
    chk(done && !cfg_hold && !rd_req, "R7 done held", 64'(done), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_valid = 1'b0; rd_data = 8'h00;
    run(3,   1'b0, 0, 1'b1, 32);
    run(91,  1'b1, 2, 1'b0, 32);
    run(200, 1'b1, 1, 1'b1, 32);
    run(55,  1'b1, 0, 1'b0, 7);
    rst_n = 1'b0;
    #1;
    chk(!done && cfg_hold && master_word == 0 && !rd_req, "R8 reset mid-fetch",
        64'(master_word), 64'd0);
    run(17,  1'b0, 3, 1'b0, 32);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule